// File: doc/BRIEF.md
# Transmit Completion Auto-Release Controller

This block decides what happens to each queued transmit packet once the MAC reports it finished. Every completion event carries a packet number, a success flag and a fatal-error flag. With the auto-release setting on, a packet that went out cleanly has its buffer pages handed straight back to the allocator and leaves no trace in the completion FIFO. Any other outcome, and every outcome with auto-release off, places the packet number in an 8-entry completion FIFO that software drains.

Interrupts are raised once per sequence, not once per packet. A sequence-end flag is set when a completion arrives while the transmit queue reports empty. A transmit-error flag is set when a packet suffers a fatal error. A fatal error also drops transmit enable, which halts the sequence. The failed packet number is held on a readout port and its pages are kept, so software can repair the cause and set enable again to resume from that packet.

Top module: `txc_release_ctrl`

## Requirements
- R1: After reset, tx_en_o, irq_seq_o, irq_err_o, fifo_ovf_o, rel_valid_o, fifo_push_o and fail_valid_o are 0 and fifo_empty_o is 1.
- R2: A completion accepted with auto_rel_i=1, ok_i=1 and fatal_i=0 gives a single-cycle rel_valid_o with rel_pkt_o equal to its number in the cycle after the strobe. It writes nothing into the FIFO.
- R3: With auto_rel_i=0, every accepted completion, successful or not, is written into the FIFO and releases no pages.
- R4: With auto_rel_i=1, a completion with ok_i=0 is written into the FIFO and releases no pages.
- R5: An accepted completion with fatal_i=1 clears tx_en_o, sets irq_err_o and fail_valid_o, loads fail_pkt_o with its number, writes it into the FIFO and never asserts rel_valid_o. When set and fatal coincide, the fatal error wins.
- R6: An accepted non-fatal completion sets irq_seq_o only if q_empty_i=1. Completions earlier in a sequence raise no interrupt.
- R7: A completion strobe while tx_en_o=0 has no effect on the release, FIFO or interrupt outputs.
- R8: irq_seq_o, irq_err_o and fifo_ovf_o stay set until cleared by irq_ack_i bit 0, bit 1 and bit 2 respectively, written as one. A new set in the same cycle as its clear wins.
- R9: The FIFO holds 8 entries and returns them in arrival order on fifo_head_o. fifo_pop_i removes the head. fifo_full_o and fifo_empty_o report the fill level.
- R10: A FIFO write while fifo_full_o=1 is dropped and sets fifo_ovf_o. The stored entries are not disturbed.
- R11: A tx_en_set_i pulse sets tx_en_o and clears fail_valid_o while fail_pkt_o keeps the failed number. fail_pkt_o changes only on a fatal error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_valid_i | input | 1 | Completion strobe from the MAC |
| done_pkt_i | input | PKT_W | Number of the completed packet |
| done_ok_i | input | 1 | Packet was sent successfully |
| done_fatal_i | input | 1 | Packet hit a fatal error |
| auto_rel_i | input | 1 | Auto-release setting |
| q_empty_i | input | 1 | Transmit queue holds no further packets |
| tx_en_set_i | input | 1 | Software pulse that sets transmit enable |
| irq_ack_i | input | 3 | Write-one-to-clear: bit 0 sequence, bit 1 error, bit 2 overflow |
| fifo_pop_i | input | 1 | Remove the FIFO head |
| rel_valid_o | output | 1 | Page-release request |
| rel_pkt_o | output | PKT_W | Packet whose pages are released |
| fifo_push_o | output | 1 | A FIFO entry was written in the last cycle |
| fifo_head_o | output | PKT_W | Oldest FIFO entry |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_full_o | output | 1 | FIFO full |
| fifo_ovf_o | output | 1 | Sticky FIFO overflow |
| irq_seq_o | output | 1 | Sticky sequence-end interrupt |
| irq_err_o | output | 1 | Sticky transmit-error interrupt |
| tx_en_o | output | 1 | Transmit enable |
| fail_pkt_o | output | PKT_W | Number of the last packet that failed fatally |
| fail_valid_o | output | 1 | A failed packet awaits restart |

## Verification
The bench switches auto-release between completions. A design that mixed up the two policies would either release pages for a failed packet or queue a successful one, and the scoreboard would catch a stray release or an unexpected FIFO entry. It also checks that a completion in the middle of a sequence leaves both interrupts low, which catches an implementation that interrupts on every packet. After a fatal error it sends another strobe while transmission is disabled. A design that kept accepting completions would then release pages or grow the FIFO. The bench also fills the FIFO and writes once more, so a design that overwrote the oldest entry or wrapped its pointers would return the wrong order or miss the overflow flag.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef struct packed {
    logic rel;      // free pages now
    logic push;     // record number in FIFO
    logic fatal;    // stop sequence
    logic seq_end;  // sequence drained
  } txc_act_t;
endpackage

// File: rtl/txc_classify.sv
module txc_classify
  import txc_pkg::*;
(
  input  logic     valid_i,
  input  logic     ok_i,
  input  logic     fatal_i,
  input  logic     auto_rel_i,
  input  logic     q_empty_i,
  input  logic     tx_en_i,
  output txc_act_t act_o
);
  logic accept, clean;
  always_comb begin
    accept        = valid_i && tx_en_i;
    clean         = ok_i && !fatal_i;
    act_o.rel     = accept && auto_rel_i && clean;
    act_o.push    = accept && !(auto_rel_i && clean);
    act_o.fatal   = accept && fatal_i;
    act_o.seq_end = accept && !fatal_i && q_empty_i;
  end
endmodule

// File: rtl/txc_fifo.sv
module txc_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
  assign drop_o  = push_i && full_o;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/txc_sticky.sv
module txc_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/txc_release_ctrl.sv
module txc_release_ctrl
  import txc_pkg::*;
#(
  parameter int PKT_W = 6,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_valid_i,
  input  logic [PKT_W-1:0] done_pkt_i,
  input  logic             done_ok_i,
  input  logic             done_fatal_i,
  input  logic             auto_rel_i,
  input  logic             q_empty_i,
  input  logic             tx_en_set_i,
  input  logic [2:0]       irq_ack_i,
  input  logic             fifo_pop_i,
  output logic             rel_valid_o,
  output logic [PKT_W-1:0] rel_pkt_o,
  output logic             fifo_push_o,
  output logic [PKT_W-1:0] fifo_head_o,
  output logic             fifo_empty_o,
  output logic             fifo_full_o,
  output logic             fifo_ovf_o,
  output logic             irq_seq_o,
  output logic             irq_err_o,
  output logic             tx_en_o,
  output logic [PKT_W-1:0] fail_pkt_o,
  output logic             fail_valid_o
);
  txc_act_t act;
  logic     drop;
  logic [2:0] flags;

  txc_classify u_cls (
    .valid_i    (done_valid_i),
    .ok_i       (done_ok_i),
    .fatal_i    (done_fatal_i),
    .auto_rel_i (auto_rel_i),
    .q_empty_i  (q_empty_i),
    .tx_en_i    (tx_en_o),
    .act_o      (act)
  );

  txc_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (act.push),
    .pop_i   (fifo_pop_i),
    .data_i  (done_pkt_i),
    .data_o  (fifo_head_o),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o),
    .drop_o  (drop)
  );

  txc_sticky #(.N(3)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({drop, act.fatal, act.seq_end}),
    .clr_i  (irq_ack_i),
    .flag_o (flags)
  );

  assign irq_seq_o  = flags[0];
  assign irq_err_o  = flags[1];
  assign fifo_ovf_o = flags[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_valid_o  <= 1'b0;
      rel_pkt_o    <= '0;
      fifo_push_o  <= 1'b0;
      tx_en_o      <= 1'b0;
      fail_valid_o <= 1'b0;
      fail_pkt_o   <= '0;
    end else begin
      rel_valid_o <= act.rel;
      if (act.rel) rel_pkt_o <= done_pkt_i;
      fifo_push_o <= act.push && !drop;
      // fatal outranks a concurrent enable request
      if (act.fatal) begin
        tx_en_o      <= 1'b0;
        fail_valid_o <= 1'b1;
        fail_pkt_o   <= done_pkt_i;
      end else if (tx_en_set_i) begin
        tx_en_o      <= 1'b1;
        fail_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
  parameter int PKT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_valid_i,
  input logic             done_ok_i,
  input logic             done_fatal_i,
  input logic             auto_rel_i,
  input logic             fifo_pop_i,
  input logic             rel_valid_o,
  input logic             fifo_empty_o,
  input logic             fifo_full_o,
  input logic             fifo_ovf_o,
  input logic             irq_err_o,
  input logic             tx_en_o,
  input logic             fail_valid_o,
  input logic [PKT_W-1:0] fail_pkt_o
);
  // R2 release only for a clean packet with auto-release on
  a_r2_release_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && tx_en_o && !(auto_rel_i && done_ok_i && !done_fatal_i)) |=> !rel_valid_o);

  // R5 fatal stops the sequence
  a_r5_fatal_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && tx_en_o && done_fatal_i) |=> (!tx_en_o && irq_err_o && fail_valid_o && !rel_valid_o));

  // R7 strobe while disabled releases nothing
  a_r7_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !tx_en_o) |=> !rel_valid_o);

  // R9 full and empty exclusive
  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && fifo_empty_o));

  // R10 write when full keeps it full and flags overflow
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && !fifo_pop_i && done_valid_i && tx_en_o && !(auto_rel_i && done_ok_i && !done_fatal_i))
    |=> (fifo_full_o && fifo_ovf_o));

  // R11 failed number moves only on a fatal error
  a_r11_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_valid_i && tx_en_o && done_fatal_i) |=> $stable(fail_pkt_o));
endmodule

bind txc_release_ctrl txc_checker #(.PKT_W(PKT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_valid_i (done_valid_i),
  .done_ok_i    (done_ok_i),
  .done_fatal_i (done_fatal_i),
  .auto_rel_i   (auto_rel_i),
  .fifo_pop_i   (fifo_pop_i),
  .rel_valid_o  (rel_valid_o),
  .fifo_empty_o (fifo_empty_o),
  .fifo_full_o  (fifo_full_o),
  .fifo_ovf_o   (fifo_ovf_o),
  .irq_err_o    (irq_err_o),
  .tx_en_o      (tx_en_o),
  .fail_valid_o (fail_valid_o),
  .fail_pkt_o   (fail_pkt_o)
);

// File: tb/sim_txc_release_ctrl.sv
module sim_txc_release_ctrl;
  localparam int CLK_P = 10;
  localparam int PKT_W = 6;

  logic clk = 0, rst_n = 0;
  logic done_valid = 0, done_ok = 0, done_fatal = 0, auto_rel = 0, q_empty = 0;
  logic tx_en_set = 0, fifo_pop = 0;
  logic [2:0] irq_ack = '0;
  logic [PKT_W-1:0] done_pkt = '0;
  logic rel_valid, fifo_push, fifo_empty, fifo_full, fifo_ovf, irq_seq, irq_err, tx_en, fail_valid;
  logic [PKT_W-1:0] rel_pkt, fifo_head, fail_pkt;

  int total = 0, fails = 0;
  bit finished = 0;
  int rel_q[$];
  int fifo_q[$];

  always #(CLK_P/2) clk = ~clk;

  txc_release_ctrl #(.PKT_W(PKT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .done_valid_i(done_valid), .done_pkt_i(done_pkt),
    .done_ok_i(done_ok), .done_fatal_i(done_fatal), .auto_rel_i(auto_rel), .q_empty_i(q_empty),
    .tx_en_set_i(tx_en_set), .irq_ack_i(irq_ack), .fifo_pop_i(fifo_pop),
    .rel_valid_o(rel_valid), .rel_pkt_o(rel_pkt), .fifo_push_o(fifo_push), .fifo_head_o(fifo_head),
    .fifo_empty_o(fifo_empty), .fifo_full_o(fifo_full), .fifo_ovf_o(fifo_ovf), .irq_seq_o(irq_seq),
    .irq_err_o(irq_err), .tx_en_o(tx_en), .fail_pkt_o(fail_pkt), .fail_valid_o(fail_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one completion, expected results queued from the requirements
  task automatic complete(input int pkt, input bit ok, input bit fatal, input bit last);
    bit acc;
    acc = tx_en;
    done_valid = 1; done_pkt = PKT_W'(pkt); done_ok = ok; done_fatal = fatal; q_empty = last;
    if (acc) begin
      if (auto_rel && ok && !fatal) rel_q.push_back(pkt);
      else if (fifo_q.size() < 8) fifo_q.push_back(pkt);
    end
    @(posedge clk); @(negedge clk);
    done_valid = 0; done_ok = 0; done_fatal = 0; q_empty = 0;
  endtask

  // monitor: release requests against the scoreboard (R2, R7)
  always @(negedge clk) begin
    if (rst_n && rel_valid) begin
      if (rel_q.size() == 0) chk(0, "R2/R7 unexpected release", int'(rel_pkt), -1);
      else begin
        int e;
        e = rel_q.pop_front();
        chk(int'(rel_pkt) == e, "R2 release number", int'(rel_pkt), e);
      end
    end
  end

  // FIFO monitor: pop everything and compare order (R3, R4, R9)
  task automatic drain(input string req);
    while (!fifo_empty) begin
      int e;
      e = (fifo_q.size() > 0) ? fifo_q.pop_front() : -1;
      chk(int'(fifo_head) == e, req, int'(fifo_head), e);
      fifo_pop = 1; @(posedge clk); @(negedge clk); fifo_pop = 0;
    end
    chk(fifo_q.size() == 0, {req, " leftover"}, 0, fifo_q.size());
  endtask

  task automatic pulse_ack(input logic [2:0] a);
    irq_ack = a; @(posedge clk); @(negedge clk); irq_ack = '0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_en && !irq_seq && !irq_err && !fifo_ovf && !rel_valid && !fifo_push && !fail_valid,
        "R1 reset outputs", {tx_en, irq_seq, irq_err, fifo_ovf}, 0);
    chk(fifo_empty, "R1 fifo empty", fifo_empty, 1);
    rst_n = 1; @(negedge clk);

    // R7: strobe before enable ignored
    auto_rel = 1;
    complete(1, 1, 0, 1);
    chk(!irq_seq && fifo_empty && !fifo_push, "R7 strobe while disabled", irq_seq, 0);

    // R11 enable
    tx_en_set = 1; @(posedge clk); @(negedge clk); tx_en_set = 0;
    chk(tx_en && !fail_valid, "R11 enable set", tx_en, 1);

    // R2 auto-release success, mid-sequence: no interrupt (R6)
    complete(5, 1, 0, 0);
    chk(fifo_empty && !fifo_push, "R2 no fifo write", fifo_empty, 1);
    chk(!irq_seq && !irq_err, "R6 no mid-sequence irq", irq_seq, 0);
    complete(6, 1, 0, 1);
    chk(irq_seq, "R6 sequence end irq", irq_seq, 1);
    repeat (3) @(negedge clk);
    chk(irq_seq, "R8 irq sticky", irq_seq, 1);
    pulse_ack(3'b001);
    chk(!irq_seq, "R8 ack clears seq irq", irq_seq, 0);

    // R4 auto-on failure goes to fifo
    complete(7, 0, 0, 0);
    chk(fifo_push && !fifo_empty, "R4 failed packet queued", fifo_push, 1);
    // R3 auto off
    auto_rel = 0;
    complete(8, 1, 0, 0);
    chk(fifo_push, "R3 success queued", fifo_push, 1);
    complete(9, 0, 0, 0);
    drain("R9 order");

    // R5 fatal
    auto_rel = 1;
    complete(10, 0, 1, 1);
    chk(!tx_en, "R5 enable cleared", tx_en, 0);
    chk(irq_err && !irq_seq, "R5 error irq", irq_err, 1);
    chk(fail_valid && fail_pkt == 10, "R5 failed number", int'(fail_pkt), 10);
    chk(!fifo_empty && fifo_head == 10, "R5 failed number queued", int'(fifo_head), 10);

    // R7 ignored while stopped
    complete(11, 1, 0, 1);
    chk(!irq_seq && fail_pkt == 10, "R7 stopped strobe ignored", irq_seq, 0);

    // R11 resume
    tx_en_set = 1; @(posedge clk); @(negedge clk); tx_en_set = 0;
    chk(tx_en && !fail_valid, "R11 resume", tx_en, 1);
    chk(fail_pkt == 10, "R11 failed number kept", int'(fail_pkt), 10);
    pulse_ack(3'b010);
    chk(!irq_err, "R8 ack clears error irq", irq_err, 0);
    drain("R5 drain");

    // R9/R10 fill and overflow
    auto_rel = 0;
    for (int i = 0; i < 8; i++) complete(20 + i, 1, 0, 0);
    chk(fifo_full, "R9 full after 8", fifo_full, 1);
    complete(28, 1, 0, 0);
    chk(fifo_ovf && fifo_full && !fifo_push, "R10 overflow flagged", fifo_ovf, 1);
    pulse_ack(3'b100);
    chk(!fifo_ovf, "R8 ack clears overflow", fifo_ovf, 0);
    drain("R10 entries intact");
    chk(fifo_empty && !fifo_full, "R9 empty after drain", fifo_empty, 1);
    chk(rel_q.size() == 0, "R2 release missing", rel_q.size(), 0);

    finished = 1;
    summary();
  end
endmodule